// File: doc/BRIEF.md
# Page Program Engine

The engine sits behind a serial memory front-end and handles the write path of a non-volatile byte array. When the front-end decodes a write instruction and its address, it pulses `wr_start`. Data bytes then arrive over a valid/ready stream and are placed into a page-sized holding buffer. The byte position starts at the low address bits and advances by one per byte, wrapping inside the page. When chip-select rises, the front-end pulses `cs_rise` and, on `cs_aligned`, reports whether the rise came exactly after a whole byte. The engine then either commits the page or drops it.

A commit starts a self-timed programming period of `PROG_CYCLES` clock cycles (at least one page length), with `busy` high. During the first `PAGE_BYTES` cycles of that period the buffer is swept in ascending position order. Every position that received a byte and does not fall in a write-protected region is driven onto the array write port. In the last busy cycle `wen_clr` pulses, so that the front-end clears its write-enable latch. The front-end uses `busy` both as the ready flag and to force status reads to all ones.

Stream rules: `in_ready` is high only while a write instruction is collecting data. A byte transfers on a clock edge where `in_valid` and `in_ready` are both high. There is no back-pressure inside a collection, so the source may send one byte per cycle.

Top module: `page_prog_engine`

## Requirements
- R1: After reset, `busy`, `in_ready`, `arr_we` and `wen_clr` are all 0.
- R2: The first byte after `wr_start` is buffered at page position `start_addr[5:0]`, and each later byte goes to the next position. A committed byte is written to address `{start_addr[14:6], position}`.
- R3: The position wraps from 63 to 0 inside the same page. When more than 64 bytes arrive, a later byte replaces the earlier byte at the same position, and only the last value is written.
- R4: A `cs_rise` with `cs_aligned`=0 discards the collected bytes. No busy period and no array write follow.
- R5: If `wen` is 0 in the cycle `wr_start` is accepted, the following bytes are still accepted on the stream but are discarded. `cs_rise` then returns the engine to idle with no busy period and no `wen_clr`.
- R6: A `cs_rise` with no byte collected since `wr_start` starts no busy period.
- R7: A commit raises `busy` in the cycle after the `cs_rise` cycle. `busy` stays high for exactly `PROG_CYCLES` cycles, and `wen_clr` is a single-cycle pulse in the last of them.
- R8: While `busy` is high, `in_ready` is 0 and `wr_start` is ignored: no collection is open when `busy` falls.
- R9: Protection code `bp_code`: 00 protects nothing; 01 protects addresses with bits [14:13]=11 (6000h–7FFFh); 10 protects bit 14 = 1 (4000h–7FFFh); 11 protects the whole array. A byte at a protected address is not written, but the busy period and `wen_clr` still run.
- R10: Array writes occur only while `busy` is high, one per cycle, in ascending page position. A write occurs only for positions that received a byte in that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Write instruction and address decoded (pulse) |
| start_addr | input | 15 | Starting byte address of the write |
| wen | input | 1 | Write-enable latch state from the front-end |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Engine can take a data byte |
| in_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip-select has risen (pulse) |
| cs_aligned | input | 1 | The rise came right after a complete byte |
| bp_code | input | 2 | Block protection code |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | 15 | Array byte address |
| arr_data | output | 8 | Array byte data |
| busy | output | 1 | Programming period in progress |
| wen_clr | output | 1 | Clear the write-enable latch (pulse) |

## Verification
The assertions assume that the front-end pulses `cs_rise` only after a `wr_start` and never in the same cycle as a byte transfer. They also assume that `bp_code` is held steady during a programming period. The bench's driver keeps to this. It changes inputs only just after a rising edge, and it separates the start pulse, the byte stream and the chip-select pulse by at least one cycle each. It changes `bp_code` only while the engine is idle.

// File: rtl/pge_pkg.sv
package pge_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_st_e;
endpackage

// File: rtl/pge_page_store.sv
module pge_page_store #(
  parameter int PAGE_BYTES = 64,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic             rd_full
);
  logic [7:0]            mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask <= '0;
    else if (clr)   mask <= '0;
    else if (wr_en) mask[wr_idx] <= 1'b1;
  end

  assign rd_data = mem[rd_idx];
  assign rd_full = mask[rd_idx];

  // R3: a byte write always leaves its position marked as holding data
  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> mask[$past(wr_idx)]);
endmodule

// File: rtl/pge_guard.sv
module pge_guard (
  input  logic [1:0] top_bits,
  input  logic [1:0] bp_code,
  output logic       locked
);
  always_comb begin
    unique case (bp_code)
      2'b00:   locked = 1'b0;
      2'b01:   locked = &top_bits;
      2'b10:   locked = top_bits[1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/pge_timer.sv
module pge_timer #(
  parameter int LEN = 100,
  localparam int CNT_W = $clog2(LEN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LEN - 1);

  assign last = busy && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST_CNT));
  a_r7_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine #(
  parameter int ADDR_W      = 15,
  parameter int PAGE_BYTES  = 64,
  parameter int PROG_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wen,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic [1:0]        bp_code,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data,
  output logic              busy,
  output logic              wen_clr
);
  import pge_pkg::*;

  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int PAGE_W   = ADDR_W - OFF_W;
  localparam int PROG_LEN = (PROG_CYCLES < PAGE_BYTES) ? PAGE_BYTES : PROG_CYCLES;
  localparam int CNT_W    = $clog2(PROG_LEN) + 1;
  localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(PAGE_BYTES);

  fill_st_e          st;
  logic              arm;
  logic              got_byte;
  logic [OFF_W-1:0]  off;
  logic [PAGE_W-1:0] page_base;

  logic              take_start, acc, commit, sweep, locked, slot_full, tmr_last;
  logic [CNT_W-1:0]  tmr_cnt;
  logic [7:0]        slot_data;

  assign in_ready   = (st == FS_FILL);
  assign take_start = wr_start && (st == FS_IDLE) && !busy;
  assign acc        = in_valid && in_ready;
  assign commit     = (st == FS_FILL) && cs_rise && cs_aligned && arm && (got_byte || acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      arm       <= 1'b0;
      got_byte  <= 1'b0;
      off       <= '0;
      page_base <= '0;
    end else if (take_start) begin
      st        <= FS_FILL;
      arm       <= wen;
      got_byte  <= 1'b0;
      off       <= start_addr[OFF_W-1:0];
      page_base <= start_addr[ADDR_W-1:OFF_W];
    end else if (st == FS_FILL) begin
      if (acc) begin
        off      <= off + 1'b1;
        got_byte <= 1'b1;
      end
      if (cs_rise) st <= FS_IDLE;
    end
  end

  pge_page_store #(.PAGE_BYTES(PAGE_BYTES)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (take_start),
    .wr_en   (acc && arm),
    .wr_idx  (off),
    .wr_data (in_data),
    .rd_idx  (tmr_cnt[OFF_W-1:0]),
    .rd_data (slot_data),
    .rd_full (slot_full)
  );

  pge_guard guard_i (
    .top_bits (page_base[PAGE_W-1 -: 2]),
    .bp_code  (bp_code),
    .locked   (locked)
  );

  pge_timer #(.LEN(PROG_LEN)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit),
    .busy  (busy),
    .cnt   (tmr_cnt),
    .last  (tmr_last)
  );

  assign sweep    = busy && (tmr_cnt < SWEEP_END);
  assign arr_we   = sweep && slot_full && !locked;
  assign arr_addr = {page_base, tmr_cnt[OFF_W-1:0]};
  assign arr_data = slot_data;
  assign wen_clr  = tmr_last;

  a_r8_no_fill_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  a_r7_busy_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && cs_aligned));
  a_r5_disarmed_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_FILL && !arm) |=> !$rose(busy));
  a_r6_empty_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_FILL && !got_byte && !in_valid) |=> !$rose(busy));
  a_r9_full_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_code == 2'b11) |-> !arr_we);
  a_r10_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
endmodule

// File: tb/page_prog_engine_tb_top.sv
module page_prog_engine_tb_top;
  localparam int AW   = 15;
  localparam int PROG = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_start = 1'b0, wen = 1'b0, in_valid = 1'b0, cs_rise = 1'b0, cs_aligned = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] in_data = '0;
  logic [1:0] bp_code = 2'b00;
  logic in_ready, arr_we, busy, wen_clr;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_data;

  always #2.5 clk = ~clk;

  page_prog_engine #(.ADDR_W(AW), .PAGE_BYTES(64), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .start_addr(start_addr), .wen(wen),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .cs_rise(cs_rise),
    .cs_aligned(cs_aligned), .bp_code(bp_code), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_data(arr_data), .busy(busy), .wen_clr(wen_clr));

  int n_chk = 0, n_bad = 0;
  logic [AW+7:0] exp_q[$];
  logic [7:0] pg_data [64];
  logic       pg_mask [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit is_locked(input logic [AW-1:0] a, input logic [1:0] bp);
    return (bp == 2'b11) || (bp == 2'b10 && a[14]) || (bp == 2'b01 && a[14:13] == 2'b11);
  endfunction

  // monitor: scoreboard of array writes (R2, R3, R9, R10)
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected write", int'({arr_addr, arr_data}), 0);
      else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        chk({arr_addr, arr_data} == e, "R2/R3/R10 write addr,data", int'({arr_addr, arr_data}), int'(e));
      end
    end
  end

  task automatic send(input logic [AW-1:0] a, input int n, input logic [7:0] seed,
                      input bit we, input bit aligned);
    int pos;
    for (int i = 0; i < 64; i++) pg_mask[i] = 1'b0;
    @(posedge clk); #1;
    wen = we; start_addr = a; wr_start = 1'b1;
    @(posedge clk); #1;
    wr_start = 1'b0;
    pos = int'(a[5:0]);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = seed + 8'(i * 7);
      pg_data[pos] = in_data; pg_mask[pos] = 1'b1;
      pos = (pos + 1) % 64;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    if (we && aligned && n > 0)
      for (int i = 0; i < 64; i++)
        if (pg_mask[i] && !is_locked({a[14:6], 6'(i)}, bp_code))
          exp_q.push_back({a[14:6], 6'(i), pg_data[i]});
    cs_aligned = aligned; cs_rise = 1'b1;
    @(posedge clk); #1;
    cs_rise = 1'b0; cs_aligned = 1'b0;
  endtask

  task automatic expect_prog(input string req, input bit poke);
    int cnt = 0, clr_at = -1, clr_n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!busy) break;
      cnt++;
      if (wen_clr) begin clr_at = cnt; clr_n++; end
      if (poke && cnt == 10) begin
        chk(!in_ready, "R8 ready low in busy", int'(in_ready), 0);
        wr_start = 1'b1; start_addr = 15'h0040; wen = 1'b1;
      end
      if (poke && cnt == 11) wr_start = 1'b0;
    end
    chk(cnt == PROG, {req, " R7 busy length"}, cnt, PROG);
    chk(clr_at == PROG && clr_n == 1, {req, " R7 wen_clr in last cycle"}, clr_at, PROG);
    chk(exp_q.size() == 0, {req, " R10 all writes seen"}, exp_q.size(), 0);
    @(negedge clk);
    chk(!in_ready, {req, " R8 idle after busy"}, int'(in_ready), 0);
  endtask

  task automatic expect_none(input string req);
    bit seen = 1'b0, clr = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      seen |= busy; clr |= wen_clr;
    end
    chk(!seen && !clr, {req, " no busy/wen_clr"}, int'({seen, clr}), 0);
    chk(exp_q.size() == 0 && !in_ready, {req, " idle, no writes"}, int'(in_ready), 0);
    exp_q.delete();
  endtask

  initial begin
    #(5 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #7;
    chk(!busy && !in_ready && !arr_we && !wen_clr, "R1 reset state",
        int'({busy, in_ready, arr_we, wen_clr}), 0);
    rst_n = 1'b1;
    // R2: four bytes mid-page
    send(15'h0123, 4, 8'h10, 1'b1, 1'b1);   expect_prog("R2", 1'b0);
    // R3: wrap inside page
    send(15'h013E, 4, 8'h20, 1'b1, 1'b1);   expect_prog("R3 wrap", 1'b0);
    // R3: 66 bytes, positions 0 and 1 overwritten
    send(15'h0200, 66, 8'h30, 1'b1, 1'b1);  expect_prog("R3 overflow", 1'b0);
    // R4: misaligned chip-select rise
    send(15'h0300, 3, 8'h40, 1'b1, 1'b0);   expect_none("R4");
    // R5: write enable low
    send(15'h0300, 3, 8'h50, 1'b0, 1'b1);   expect_none("R5");
    // R6: zero bytes
    send(15'h0300, 0, 8'h60, 1'b1, 1'b1);   expect_none("R6");
    // R8: start pulse during busy ignored
    send(15'h0400, 2, 8'h70, 1'b1, 1'b1);   expect_prog("R8", 1'b1);
    // R9: protection codes
    bp_code = 2'b01;
    send(15'h6010, 3, 8'h80, 1'b1, 1'b1);   expect_prog("R9 bp01 locked", 1'b0);
    send(15'h5FC0, 3, 8'h90, 1'b1, 1'b1);   expect_prog("R9 bp01 open", 1'b0);
    bp_code = 2'b10;
    send(15'h4000, 2, 8'hA0, 1'b1, 1'b1);   expect_prog("R9 bp10 locked", 1'b0);
    send(15'h3FC0, 2, 8'hB0, 1'b1, 1'b1);   expect_prog("R9 bp10 open", 1'b0);
    bp_code = 2'b11;
    send(15'h0000, 2, 8'hC0, 1'b1, 1'b1);   expect_prog("R9 bp11", 1'b0);
    bp_code = 2'b00;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule